// File: doc/BRIEF.md
# Indirect Memory Address Register with Level Auto-Increment

This block holds the target of an indirect access into an external memory whose logical words can be wider than the physical device. A 17-bit word address selects the word. A 2-bit level selects which physical slice of that word an access reaches. A host writes and reads the register as one 64-bit value. The address and the level are driven continuously to the access engine.

Each time the access engine completes an indirect access, it raises a one-cycle done strobe. If level auto-increment is enabled, the level then steps forward. The wrap point follows the configured number of slices per word. A level that is already past the configured depth keeps counting up to 3 and then wraps to 0; it is not clamped.

A separate output tells the result path which slice feeds the automatic data FIFO. That slice is normally level 0. It is level 1 when a single memory device is shared by both buses.

Top module: `imi_addr_reg`

## Requirements
- R1: After the asynchronous active-low reset, the word address is 0, the level is 0 and the read value is all zero.
- R2: A host write loads the word address from data bits 16:0 and the level from data bits 23:22, with level code 00..11 meaning slice 0..3. Both are visible on the outputs and in the read value from the next cycle.
- R3: Read bits 63:24 and 21:17 always return zero, whatever value was written to them.
- R4: With depth code 00 (one slice), an access-done strobe leaves the level unchanged.
- R5: With depth code 01 (two slices), each strobe moves the level from 0 to 1, and from 1 back to 0.
- R6: With depth code 10 or 11 (four slices), each strobe moves the level 0, 1, 2, 3 and then back to 0.
- R7: With depth code 01 and a level of 2, successive strobes move the level to 3 and then to 0.
- R8: The level changes only on a strobe while auto-increment is high, and a strobe never alters the word address.
- R9: When a host write and a strobe fall in the same cycle, the written level is kept and the increment is dropped.
- R10: The FIFO slice output is 0 when the shared-device input is low, and 1 when it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host write strobe |
| wr_data_i | input | 64 | Host write data |
| rd_data_o | output | 64 | Register read value |
| depth_i | input | 2 | Slices per word: 00=1, 01=2, 10/11=4 |
| auto_inc_i | input | 1 | Level auto-increment enable |
| access_done_i | input | 1 | One-cycle pulse at the end of an indirect access |
| shared_dev_i | input | 1 | Both buses share a single memory device |
| word_addr_o | output | 17 | Word address to the access engine |
| level_o | output | 2 | Slice level to the access engine |
| fifo_level_o | output | 2 | Slice that feeds the automatic data FIFO |

## Verification
The bench builds the block with its default parameters: a 17-bit address, a 2-bit level and a 64-bit host word. These widths match the field positions that the host software decodes. With a 2-bit level, every level value and every depth code can be reached within a few strobes. The bench therefore walks each full wrap sequence, the out-of-range level under two-slice depth, and the write-versus-strobe collision. It also writes ones to every reserved bit to show that they read back as zero.

// File: rtl/imi_pkg.sv
package imi_pkg;
  localparam int unsigned DATA_W   = 64;
  localparam int unsigned ADDR_W   = 17;
  localparam int unsigned LVL_W    = 2;
  localparam int unsigned ADDR_LSB = 0;
  localparam int unsigned LVL_LSB  = 22;

  typedef enum logic [1:0] {
    DEPTH_1 = 2'b00,
    DEPTH_2 = 2'b01,
    DEPTH_4 = 2'b10,
    DEPTH_X = 2'b11
  } depth_e;
endpackage

// File: rtl/imi_level_step.sv
module imi_level_step
  import imi_pkg::*;
#(
  parameter int unsigned LW = LVL_W
) (
  input  logic [LW-1:0] lvl_i,
  input  logic [1:0]    depth_i,
  output logic [LW-1:0] lvl_o
);
  localparam logic [LW-1:0] ONE = LW'(1);

  always_comb begin
    unique case (depth_e'(depth_i))
      DEPTH_1: lvl_o = lvl_i;
      // two slices: 1 wraps, out-of-range values run on to the top and wrap
      DEPTH_2: lvl_o = (lvl_i == ONE) ? '0 : lvl_i + ONE;
      default: lvl_o = lvl_i + ONE;
    endcase
  end
endmodule

// File: rtl/imi_reg.sv
module imi_reg
  import imi_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned LW = LVL_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [LW-1:0] wr_lvl_i,
  input  logic          inc_i,
  input  logic [LW-1:0] inc_lvl_i,
  input  logic [1:0]    depth_i,
  output logic [AW-1:0] addr_o,
  output logic [LW-1:0] lvl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      lvl_o  <= '0;
    end else if (wr_en_i) begin
      addr_o <= wr_addr_i;
      lvl_o  <= wr_lvl_i;
    end else if (inc_i) begin
      lvl_o  <= inc_lvl_i;
    end
  end

  // R2
  wr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (addr_o == $past(wr_addr_i)) && (lvl_o == $past(wr_lvl_i)));

  // R9
  wr_priority_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && inc_i) |=> lvl_o == $past(wr_lvl_i));

  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && !inc_i) |=> $stable(lvl_o) && $stable(addr_o));

  // R8
  inc_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && inc_i) |=> $stable(addr_o));

  // R4
  depth1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && depth_i == 2'b00) |=> $stable(lvl_o));

  // R5
  depth2_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && inc_i && depth_i == 2'b01 && lvl_o == LW'(1)) |=> lvl_o == '0);
endmodule

// File: rtl/imi_addr_reg.sv
module imi_addr_reg
  import imi_pkg::*;
#(
  parameter int unsigned DW  = DATA_W,
  parameter int unsigned AW  = ADDR_W,
  parameter int unsigned LW  = LVL_W,
  parameter int unsigned A_LSB = ADDR_LSB,
  parameter int unsigned L_LSB = LVL_LSB
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [DW-1:0] rd_data_o,
  input  logic [1:0]    depth_i,
  input  logic          auto_inc_i,
  input  logic          access_done_i,
  input  logic          shared_dev_i,
  output logic [AW-1:0] word_addr_o,
  output logic [LW-1:0] level_o,
  output logic [LW-1:0] fifo_level_o
);
  localparam int unsigned A_MSB = A_LSB + AW - 1;
  localparam int unsigned L_MSB = L_LSB + LW - 1;

  logic [LW-1:0] next_lvl;
  logic          inc;

  assign inc = access_done_i & auto_inc_i;

  imi_level_step #(.LW(LW)) u_step (
    .lvl_i   (level_o),
    .depth_i (depth_i),
    .lvl_o   (next_lvl)
  );

  imi_reg #(.AW(AW), .LW(LW)) u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_data_i[A_MSB:A_LSB]),
    .wr_lvl_i  (wr_data_i[L_MSB:L_LSB]),
    .inc_i     (inc),
    .inc_lvl_i (next_lvl),
    .depth_i   (depth_i),
    .addr_o    (word_addr_o),
    .lvl_o     (level_o)
  );

  // reserved bits read as zero
  always_comb begin
    rd_data_o = '0;
    rd_data_o[A_MSB:A_LSB] = word_addr_o;
    rd_data_o[L_MSB:L_LSB] = level_o;
  end

  // shared single device returns slice at level 1, otherwise level 0
  assign fifo_level_o = shared_dev_i ? LW'(1) : '0;

  // R8
  no_auto_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && !auto_inc_i) |=> $stable(level_o));

  // R3
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(rd_data_o) == $countones(word_addr_o) + $countones(level_o));
endmodule

// File: tb/imi_addr_reg_tb.sv
module imi_addr_reg_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [63:0] wr_data = '0;
  logic [63:0] rd_data;
  logic [1:0]  depth = 2'b00;
  logic        auto_inc = 1'b0;
  logic        done = 1'b0;
  logic        shared = 1'b0;
  logic [16:0] addr;
  logic [1:0]  lvl;
  logic [1:0]  fifo_lvl;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  imi_addr_reg u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .depth_i(depth), .auto_inc_i(auto_inc),
    .access_done_i(done), .shared_dev_i(shared), .word_addr_o(addr),
    .level_o(lvl), .fifo_level_o(fifo_lvl)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] pack(logic [16:0] a, logic [1:0] l);
    logic [63:0] v = '0;
    v[16:0] = a;
    v[23:22] = l;
    return v;
  endfunction

  // drive at negedge, takes effect at next posedge, outputs checked at following negedge
  task automatic host_write(logic [63:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic strobe();
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 addr", 64'(addr), 64'd0);
    check("R1 lvl", 64'(lvl), 64'd0);
    check("R1 rd", rd_data, 64'd0);
  endtask

  task automatic t_write();
    host_write(pack(17'h1ABCD, 2'b10));
    check("R2 addr", 64'(addr), 64'h1ABCD);
    check("R2 lvl", 64'(lvl), 64'd2);
    check("R2 rd", rd_data, pack(17'h1ABCD, 2'b10));
    host_write('1);
    check("R3 rsvd", rd_data, pack(17'h1FFFF, 2'b11));
    host_write(64'hFFFF_FFFF_FF3E_0000);
    check("R3 rsvd only", rd_data, 64'd0);
  endtask

  task automatic t_depth1();
    depth = 2'b00; auto_inc = 1'b1;
    host_write(pack(17'h00055, 2'b01));
    strobe();
    check("R4 lvl", 64'(lvl), 64'd1);
    strobe();
    check("R4 lvl2", 64'(lvl), 64'd1);
  endtask

  task automatic t_depth2();
    depth = 2'b01; auto_inc = 1'b1;
    host_write(pack(17'h00123, 2'b00));
    strobe();
    check("R5 0to1", 64'(lvl), 64'd1);
    strobe();
    check("R5 1to0", 64'(lvl), 64'd0);
    check("R8 addr kept", 64'(addr), 64'h00123);
  endtask

  task automatic t_depth4(logic [1:0] code);
    depth = code; auto_inc = 1'b1;
    host_write(pack(17'h00777, 2'b00));
    for (int i = 1; i <= 4; i++) begin
      strobe();
      check("R6 step", 64'(lvl), 64'(i % 4));
    end
  endtask

  task automatic t_out_of_range();
    depth = 2'b01; auto_inc = 1'b1;
    host_write(pack(17'h00009, 2'b10));
    strobe();
    check("R7 2to3", 64'(lvl), 64'd3);
    strobe();
    check("R7 3to0", 64'(lvl), 64'd0);
  endtask

  task automatic t_gate();
    depth = 2'b10; auto_inc = 1'b0;
    host_write(pack(17'h00ABC, 2'b01));
    strobe();
    check("R8 no auto", 64'(lvl), 64'd1);
    auto_inc = 1'b1;
    @(negedge clk);
    check("R8 no strobe", 64'(lvl), 64'd1);
    strobe();
    check("R8 inc", 64'(lvl), 64'd2);
    check("R8 addr", 64'(addr), 64'h00ABC);
  endtask

  task automatic t_collide();
    depth = 2'b10; auto_inc = 1'b1;
    host_write(pack(17'h00001, 2'b00));
    done = 1'b1;
    host_write(pack(17'h00002, 2'b10));
    done = 1'b0;
    check("R9 lvl", 64'(lvl), 64'd2);
    check("R9 addr", 64'(addr), 64'h00002);
  endtask

  task automatic t_fifo();
    shared = 1'b0;
    #1 check("R10 low", 64'(fifo_lvl), 64'd0);
    shared = 1'b1;
    #1 check("R10 high", 64'(fifo_lvl), 64'd1);
    shared = 1'b0;
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_write();
    t_depth1();
    t_depth2();
    t_depth4(2'b10);
    t_depth4(2'b11);
    t_out_of_range();
    t_gate();
    t_collide();
    t_fifo();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule